// File: doc/BRIEF.md
# Limit Compare Interrupt Status Unit

The unit watches a stream of 8-bit measurement results from six channels: an on-die temperature, a remote temperature (which can also serve as a plain voltage input), three more voltage inputs and the supply voltage. It checks each result against a high and a low threshold for its channel. Any result outside its window sets a sticky bit in one of two 8-bit status registers. A masked OR of those bits drives one interrupt line, and its polarity can be chosen.

A read of a status register clears only those bits whose cause has gone away. A bit whose channel is still out of range at that moment stays set. A new out-of-window result that arrives in the same cycle as a clearing read leaves its bit set. A software reset input clears both registers. Thresholds and masks are written through simple write strobes, and the bus protocol that carries them lies outside this block.

Top module: `limit_irq_unit`

## Requirements
- R1: After rst_n is low for one rising edge, both status registers read 00h, both masks are 00h, and the thresholds hold their start values: channel 0 high 64h, low C9h; channels 1 to 4 high FFh, low 00h; channel 5 high C7h, low 62h.
- R2: The high test fires only when the result is strictly greater than the high threshold. A result equal to the high threshold does not fire it.
- R3: The low test fires when the result is less than or equal to the low threshold.
- R4: Channel 0, and channel 1 when ain_mode is 0, are compared as two's complement. Channels 2 to 5, and channel 1 when ain_mode is 1, are compared as unsigned.
- R5: Status register 0 (rd_addr 0) uses this bit layout: bit 0 is channel 0 high, bit 1 is channel 0 low, bit 2 and bit 3 are for channel 1 (see R6), bit 4 is the sensor fault, and bits 5, 6 and 7 are set by either test on channels 2, 3 and 4. Status register 1 (rd_addr 1) bit 0 is set by either test on channel 5. All other bits read 0, and results on channel codes 6 and 7 change nothing.
- R6: When ain_mode is 0, bit 2 is the channel 1 high test and bit 3 is the channel 1 low test. When ain_mode is 1, bit 2 is set by either channel 1 test and bit 3 is never set.
- R7: Once set, a status bit stays set even after its channel returns inside the window, until a clearing read or a software reset.
- R8: A cycle with rd_strobe high clears the bits of the register selected by rd_addr only where the cause no longer holds. For a channel, the cause is its most recent evaluation. For bit 4, the cause is the ext_fault level. Bits whose cause still holds stay set.
- R9: An out-of-window result in the same cycle as a clearing read of its register leaves the bit set.
- R10: soft_rst high clears both status registers at the next rising edge.
- R11: ext_fault high at a rising edge sets status register 0 bit 4.
- R12: Let pending be true when any status bit is 1 and its mask bit is 0. irq equals pending when irq_active_high is 1, and equals the inverse of pending when irq_active_high is 0.
- R13: A write with lim_wr_sel = 2*channel sets that channel's high threshold, and lim_wr_sel = 2*channel+1 sets its low threshold. Values of lim_wr_sel of 12 or more are ignored. mask_wr_sel picks mask 0 or mask 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_rst | input | 1 | Clears both status registers |
| res_valid | input | 1 | Result strobe |
| res_chan | input | 3 | Channel code of the result |
| res_data | input | 8 | Result value |
| ain_mode | input | 1 | 1: channel 1 is a voltage input |
| ext_fault | input | 1 | Remote sensor open/short indication |
| lim_wr_en | input | 1 | Threshold write strobe |
| lim_wr_sel | input | 4 | Threshold index |
| lim_wr_data | input | 8 | Threshold value |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_sel | input | 1 | Mask register select |
| mask_wr_data | input | 8 | Mask value (1 blocks the bit) |
| rd_strobe | input | 1 | Clearing read strobe |
| rd_addr | input | 1 | Status register select |
| rd_data | output | 8 | Selected status register, combinational |
| irq_active_high | input | 1 | Interrupt polarity |
| irq | output | 1 | Interrupt output |

## Verification
A clearing read and a fresh evaluation of the same channel can land on the same edge. The bench provokes this by raising rd_strobe in the same cycle as res_valid for channel 0, with a value above its high threshold. It also covers a read made while the channel or the fault input is still out of range. It judges both cases by reading the register back after the edge and expecting the bit to still be set. It also confirms the opposite case: once the cause has ended, the same read does clear the bit.

// File: rtl/limit_irq_pkg.sv
// Package: shared widths and threshold start values for the limit unit.
// Assumes six result channels, two thresholds per channel, 8-bit results.
package limit_irq_pkg;
    localparam int DATA_W = 8;
    localparam int N_CHAN = 6;
    localparam int CHAN_W = 3;
    localparam int N_LIM  = 2 * N_CHAN;
    localparam int LSEL_W = 4;
    localparam int STAT_W = 16;

    // Start value of threshold idx (even = high, odd = low).
    function automatic logic [DATA_W-1:0] lim_start(input int idx);
        case (idx)
            0:       return 8'h64;
            1:       return 8'hC9;
            10:      return 8'hC7;
            11:      return 8'h62;
            default: return (idx % 2 == 0) ? 8'hFF : 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/limit_irq_thresholds.sv
// Threshold store: one register per threshold, loaded at reset with its
// start value, written by index. Out-of-range indices are ignored.
module limit_irq_thresholds
    import limit_irq_pkg::*;
#(
    parameter int NL = N_LIM,
    parameter int DW = DATA_W,
    parameter int SW = LSEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] lim [NL]
);
    for (genvar g = 0; g < NL; g++) begin : g_lim
        // Holds one threshold; reset value comes from the package table.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lim[g] <= lim_start(g);
            else if (wr_en && (wr_sel == SW'(g)))
                lim[g] <= wr_data;
        end
    end
endmodule

// File: rtl/limit_irq_compare.sv
// Window comparator: selects the channel's thresholds and tests the result.
// Above is strict (>), below is inclusive (<=). Signed for temperature.
module limit_irq_compare
    import limit_irq_pkg::*;
#(
    parameter int NC = N_CHAN,
    parameter int DW = DATA_W,
    parameter int CW = CHAN_W
) (
    input  logic [DW-1:0] lim [2*NC],
    input  logic [CW-1:0] chan,
    input  logic [DW-1:0] data,
    input  logic          ain_mode,
    output logic          above,
    output logic          below
);
    logic [DW-1:0] hi, lo;
    logic          is_signed;

    // Pick the thresholds belonging to the addressed channel.
    always_comb begin
        hi = '0;
        lo = '0;
        for (int i = 0; i < NC; i++) begin
            if (chan == CW'(i)) begin
                hi = lim[2*i];
                lo = lim[2*i+1];
            end
        end
    end

    // Temperature channels use two's complement ordering.
    assign is_signed = (chan == CW'(0)) || ((chan == CW'(1)) && !ain_mode);

    // Evaluate both window edges in the chosen number format.
    always_comb begin
        if (is_signed) begin
            above = $signed(data) >  $signed(hi);
            below = $signed(data) <= $signed(lo);
        end else begin
            above = data >  hi;
            below = data <= lo;
        end
    end
endmodule

// File: rtl/limit_irq_status.sv
// Status store: sticky event bits plus a record of each bit's live cause.
// Priority per edge: software reset, then new event, then clearing read.
module limit_irq_status
    import limit_irq_pkg::*;
#(
    parameter int CW = CHAN_W,
    parameter int SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          ev_valid,
    input  logic [CW-1:0] ev_chan,
    input  logic          above,
    input  logic          below,
    input  logic          ain_mode,
    input  logic          ext_fault,
    input  logic          rd_clr,
    input  logic          rd_sel,
    output logic [SW-1:0] status
);
    logic [SW-1:0] cause_q, cause_n, ev, status_n;
    logic          either;

    assign either = above | below;

    // Map the current evaluation onto status bit positions.
    always_comb begin
        ev      = '0;
        cause_n = cause_q;
        if (ev_valid) begin
            case (ev_chan)
                CW'(0): begin
                    ev[0] = above;  ev[1] = below;
                    cause_n[1:0] = {below, above};
                end
                CW'(1): begin
                    ev[2] = ain_mode ? either : above;
                    ev[3] = ain_mode ? 1'b0 : below;
                    cause_n[3:2] = ev[3:2];
                end
                CW'(2): begin ev[5] = either; cause_n[5] = either; end
                CW'(3): begin ev[6] = either; cause_n[6] = either; end
                CW'(4): begin ev[7] = either; cause_n[7] = either; end
                CW'(5): begin ev[8] = either; cause_n[8] = either; end
                default: ;
            endcase
        end
        ev[4]      = ext_fault;
        cause_n[4] = ext_fault;
    end

    // Next status: clear corrected bits on read, then add new events.
    always_comb begin
        status_n = status;
        if (rd_clr) begin
            if (rd_sel) status_n[15:8] = status[15:8] & cause_n[15:8];
            else        status_n[7:0]  = status[7:0]  & cause_n[7:0];
        end
        status_n = status_n | ev;
    end

    // Register status and causes; software reset empties both.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            status  <= '0;
            cause_q <= '0;
        end else begin
            status  <= status_n;
            cause_q <= cause_n;
        end
    end
endmodule

// File: rtl/limit_irq_unit.sv
// Top: thresholds, comparator, status store, masks and interrupt output.
// Assumes results arrive one per cycle with a channel code; read is 1 cycle.
module limit_irq_unit
    import limit_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              res_valid,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic [DATA_W-1:0] res_data,
    input  logic              ain_mode,
    input  logic              ext_fault,
    input  logic              lim_wr_en,
    input  logic [LSEL_W-1:0] lim_wr_sel,
    input  logic [DATA_W-1:0] lim_wr_data,
    input  logic              mask_wr_en,
    input  logic              mask_wr_sel,
    input  logic [7:0]        mask_wr_data,
    input  logic              rd_strobe,
    input  logic              rd_addr,
    output logic [7:0]        rd_data,
    input  logic              irq_active_high,
    output logic              irq
);
    logic [DATA_W-1:0] lim [N_LIM];
    logic              cmp_above, cmp_below;
    logic [STAT_W-1:0] status_w, mask_w;
    logic              pending;

    limit_irq_thresholds u_thr (
        .clk(clk), .rst_n(rst_n), .wr_en(lim_wr_en),
        .wr_sel(lim_wr_sel), .wr_data(lim_wr_data), .lim(lim)
    );

    limit_irq_compare u_cmp (
        .lim(lim), .chan(res_chan), .data(res_data), .ain_mode(ain_mode),
        .above(cmp_above), .below(cmp_below)
    );

    limit_irq_status u_stat (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .ev_valid(res_valid), .ev_chan(res_chan),
        .above(cmp_above), .below(cmp_below), .ain_mode(ain_mode),
        .ext_fault(ext_fault), .rd_clr(rd_strobe), .rd_sel(rd_addr),
        .status(status_w)
    );

    // Mask registers: a 1 keeps the matching status bit off the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_w <= '0;
        else if (mask_wr_en) begin
            if (mask_wr_sel) mask_w[15:8] <= mask_wr_data;
            else             mask_w[7:0]  <= mask_wr_data;
        end
    end

    // Read mux and interrupt output with selectable polarity.
    assign rd_data = rd_addr ? status_w[15:8] : status_w[7:0];
    assign pending = |(status_w & ~mask_w);
    assign irq     = irq_active_high ? pending : !pending;
endmodule

// File: rtl/limit_irq_unit_chk.sv
// Checker: temporal properties of the limit unit, attached by bind.
module limit_irq_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        res_valid,
    input logic [2:0]  res_chan,
    input logic        cmp_above,
    input logic        rd_strobe,
    input logic        rd_addr,
    input logic [15:0] status_w,
    input logic [15:0] mask_w,
    input logic        irq_active_high,
    input logic        irq
);
    a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (status_w == 16'h0));

    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_chan == 3'd0 && cmp_above && !soft_rst) |=> status_w[0]);

    a_r7_sticky_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !(rd_strobe && !rd_addr))
        |=> ((status_w[7:0] & $past(status_w[7:0])) == $past(status_w[7:0])));

    a_r7_sticky_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !(rd_strobe && rd_addr))
        |=> ((status_w[15:8] & $past(status_w[15:8])) == $past(status_w[15:8])));

    a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_active_high && ((status_w & ~mask_w) == 16'h0)) |-> !irq);

    a_r5_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_w[15:9] == 7'h0);
endmodule

bind limit_irq_unit limit_irq_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .res_valid(res_valid),
    .res_chan(res_chan), .cmp_above(cmp_above), .rd_strobe(rd_strobe),
    .rd_addr(rd_addr), .status_w(status_w), .mask_w(mask_w),
    .irq_active_high(irq_active_high), .irq(irq)
);

// File: tb/limit_irq_unit_bench.sv
`timescale 1ns/1ps
module limit_irq_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, soft_rst = 1'b0, res_valid = 1'b0;
    logic [2:0] res_chan = '0;
    logic [7:0] res_data = '0;
    logic       ain_mode = 1'b0, ext_fault = 1'b0;
    logic       lim_wr_en = 1'b0;
    logic [3:0] lim_wr_sel = '0;
    logic [7:0] lim_wr_data = '0;
    logic       mask_wr_en = 1'b0, mask_wr_sel = 1'b0;
    logic [7:0] mask_wr_data = '0;
    logic       rd_strobe = 1'b0, rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       irq_active_high = 1'b1;
    logic       irq;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    limit_irq_unit u_limit_irq_unit (.*);

    // {ain_mode, chan, data, expected status (reg1:reg0)}, defaults loaded
    localparam int NV = 17;
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 3'd0, 8'h64, 16'h0000},  // R2 equal to high
        {1'b0, 3'd0, 8'h65, 16'h0001},  // R2 above high
        {1'b0, 3'd0, 8'hC9, 16'h0002},  // R3 equal to low
        {1'b0, 3'd0, 8'hCA, 16'h0000},  // R3 just above low
        {1'b0, 3'd0, 8'h80, 16'h0002},  // R4 signed -128
        {1'b0, 3'd1, 8'h80, 16'h0008},  // R6 ext low
        {1'b0, 3'd1, 8'h05, 16'h0004},  // R6 ext high (5 > -1)
        {1'b1, 3'd1, 8'h80, 16'h0000},  // R4 unsigned window
        {1'b1, 3'd1, 8'h00, 16'h0004},  // R6 ain low on bit 2
        {1'b0, 3'd2, 8'h00, 16'h0020},  // R5
        {1'b0, 3'd3, 8'h00, 16'h0040},  // R5
        {1'b0, 3'd4, 8'h00, 16'h0080},  // R5
        {1'b0, 3'd4, 8'h7F, 16'h0000},  // R5 in window
        {1'b0, 3'd5, 8'hC8, 16'h0100},  // R5 supply high
        {1'b0, 3'd5, 8'h62, 16'h0100},  // R5 supply low
        {1'b0, 3'd5, 8'h80, 16'h0000},  // R5 supply inside
        {1'b0, 3'd6, 8'h00, 16'h0000}   // R5 unused code
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic peek(output logic [15:0] st);
        rd_addr = 1'b1; #0.1; st[15:8] = rd_data;
        rd_addr = 1'b0; #0.1; st[7:0]  = rd_data;
    endtask

    task automatic cycle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic result(input logic [2:0] c, input logic [7:0] d);
        res_valid = 1'b1; res_chan = c; res_data = d;
        cycle();
        res_valid = 1'b0;
    endtask

    task automatic clr_read(input logic a);
        rd_strobe = 1'b1; rd_addr = a;
        cycle();
        rd_strobe = 1'b0;
    endtask

    task automatic sreset();
        soft_rst = 1'b1; cycle(); soft_rst = 1'b0;
    endtask

    initial begin
        #150000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        peek(st);
        check("R1 status", {16'h0, st}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // Table walk: each vector from a clean status.
        for (int i = 0; i < NV; i++) begin
            sreset();
            ain_mode = VEC[i][27];
            result(VEC[i][26:24], VEC[i][23:16]);
            peek(st);
            check($sformatf("R2-vector %0d", i), {16'h0, st}, {16'h0, VEC[i][15:0]});
        end
        ain_mode = 1'b0;
        sreset();

        // R7 sticky
        result(3'd0, 8'h65);
        result(3'd0, 8'h30);
        peek(st);
        check("R7 sticky", {16'h0, st}, 32'h1);
        // R8 cleared after correction
        clr_read(1'b0);
        peek(st);
        check("R8 cleared", {16'h0, st}, 32'h0);
        // R8 kept while still held
        result(3'd0, 8'h66);
        clr_read(1'b0);
        peek(st);
        check("R8 held", {16'h0, st}, 32'h1);
        // R8 read of other register leaves this one
        result(3'd0, 8'h30);
        clr_read(1'b1);
        peek(st);
        check("R8 other reg", {16'h0, st}, 32'h1);
        clr_read(1'b0);
        // R9 event and read in same cycle
        res_valid = 1'b1; res_chan = 3'd0; res_data = 8'h70;
        rd_strobe = 1'b1; rd_addr = 1'b0;
        cycle();
        res_valid = 1'b0; rd_strobe = 1'b0;
        peek(st);
        check("R9 event wins", {16'h0, st}, 32'h1);

        // R10 soft reset clears both registers
        result(3'd5, 8'hF0);
        sreset();
        peek(st);
        check("R10 soft reset", {16'h0, st}, 32'h0);

        // R11 fault
        ext_fault = 1'b1; cycle();
        clr_read(1'b0);
        peek(st);
        check("R11 fault held", {16'h0, st}, 32'h10);
        ext_fault = 1'b0; cycle();
        peek(st);
        check("R11 fault sticky", {16'h0, st}, 32'h10);
        clr_read(1'b0);
        peek(st);
        check("R11 fault cleared", {16'h0, st}, 32'h0);

        // R12 masking and polarity
        result(3'd0, 8'h65);
        check("R12 irq on", {31'h0, irq}, 32'h1);
        mask_wr_en = 1'b1; mask_wr_sel = 1'b0; mask_wr_data = 8'h01;
        cycle(); mask_wr_en = 1'b0;
        check("R12 masked", {31'h0, irq}, 32'h0);
        irq_active_high = 1'b0; #0.1;
        check("R12 low polarity idle", {31'h0, irq}, 32'h1);
        mask_wr_en = 1'b1; mask_wr_data = 8'h00;
        cycle(); mask_wr_en = 1'b0;
        check("R12 low polarity active", {31'h0, irq}, 32'h0);
        irq_active_high = 1'b1;
        mask_wr_en = 1'b1; mask_wr_sel = 1'b1; mask_wr_data = 8'hFF;
        cycle(); mask_wr_en = 1'b0;
        check("R13 mask sel 1 leaves reg 0", {31'h0, irq}, 32'h1);
        mask_wr_en = 1'b1; mask_wr_data = 8'h00; cycle(); mask_wr_en = 1'b0;

        // R13 threshold writes
        sreset();
        lim_wr_en = 1'b1; lim_wr_sel = 4'd0; lim_wr_data = 8'h10;
        cycle();
        lim_wr_sel = 4'd13; lim_wr_data = 8'h00;
        cycle(); lim_wr_en = 1'b0;
        result(3'd0, 8'h10);
        peek(st);
        check("R13 new high equal", {16'h0, st}, 32'h0);
        result(3'd0, 8'h11);
        peek(st);
        check("R13 new high above", {16'h0, st}, 32'h1);
        sreset();
        result(3'd4, 8'h01);
        peek(st);
        check("R13 bad index ignored", {16'h0, st}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule